// File: doc/BRIEF.md
# Pixel Time-Interval Converter: Control and Coarse Counting

This block is the digital core of a per-pixel time-to-digital converter. It measures the interval from a photon detection to a shared stop signal. A conversion is triggered by an event: either the detector's quench circuit or, when selected, a test pulse that needs no sensor. At the first global clock edge after the event, the block freezes the fine delay-line state, which arrives as a 16-bit thermometer vector, and encodes it into a 4-bit fine code. From that edge on, a coarse counter counts global clock periods until the shared stop arrives. At stop, the fine code, the coarse count and a validity flag are latched into a result register. The register holds until the pixel readout acknowledges it, and the pixel then returns to waiting.

With no event the control logic stays in its waiting state and the counter does not move. Only the first event of a cycle is recorded. A stop that arrives with no event produces a result that is marked invalid. A stop that arrives too late saturates the counter and raises an overflow flag.

All inputs are treated as synchronous to `clk`. An event, stop or acknowledge counts at every rising edge at which it is sampled high.

Top module: `pix_tdc_core`

## Requirements
- R1: After reset, `res_done`, `res_valid`, `res_ovf`, `res_fine` and `res_coarse` are all zero and the converter is waiting for an event.
- R2: A conversion begins only at a rising edge at which the selected start source is high. While waiting with no start and no stop, the outputs do not change.
- R3: When `dummy_sel` is 1, only `dummy_start` can begin a conversion and `det_start` is ignored. When `dummy_sel` is 0, the roles are swapped.
- R4: The fine code is the position of the first stage i (bit 0 is the first stage) at which `dline_taps[i]` and `dline_taps[i+1]` are both 0. A 0 is assumed above bit 15. If no such pair exists, the code is 16. The code is capped at 15, and a single isolated 0 inside the run of ones does not end the run. The vector is sampled only at the starting edge.
- R5: The coarse result equals the number of rising edges after the starting edge, up to and including the edge at which `stop` is high.
- R6: The coarse count saturates at 1023. If stop comes more than 1023 edges after the start, the result is 1023 with `res_ovf` = 1. Otherwise `res_ovf` = 0.
- R7: At the stop edge of a conversion, `res_done` and `res_valid` rise together with the fine and coarse results. They then hold unchanged, ignoring start and stop, until `rd_ack` is sampled high.
- R8: A stop sampled while waiting (including one coinciding with a start) gives `res_done` = 1 and `res_valid` = 0, with fine, coarse and overflow all 0.
- R9: Start events after the first one in a conversion are ignored. The fine code and the coarse timing come from the first event.
- R10: `rd_ack` while a result is held clears all result outputs to zero and returns the converter to waiting, so that a following event starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock that times the coarse count |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_start | input | 1 | Start event from the detector front end |
| dummy_start | input | 1 | Test start event that needs no sensor |
| dummy_sel | input | 1 | 1 selects `dummy_start` as the start source |
| dline_taps | input | 16 | Thermometer state of the fine delay line |
| stop | input | 1 | Shared stop that ends the measurement |
| rd_ack | input | 1 | Readout acknowledge; clears the result |
| res_done | output | 1 | A result (valid or not) is held |
| res_valid | output | 1 | Held result comes from a real conversion |
| res_ovf | output | 1 | Coarse count saturated |
| res_fine | output | 4 | Latched fine code |
| res_coarse | output | 10 | Latched coarse count |

## Verification
The assertions assume that the start, stop and acknowledge inputs are clean synchronous levels, and that the thermometer vector is meaningful only at the edge that starts a conversion. They also assume that a held result stays until an acknowledge arrives. The stimulus drives every input on the falling edge and keeps `rd_ack` low except after a result is held. Between conversions it scrambles the taps so that sampling at the wrong edge would show. Random interval lengths and tap patterns, some with a single bubble, are mixed with directed cases at the saturation boundary and with stops that come with no start.

// File: rtl/pix_tdc_pkg.sv
package pix_tdc_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } tdc_state_e;

endpackage

// File: rtl/pix_therm_enc.sv
module pix_therm_enc #(
    parameter int STAGES = 16,
    localparam int CODE_W = $clog2(STAGES)
) (
    input  logic [STAGES-1:0] taps,
    output logic [CODE_W-1:0] code
);
    localparam int IDX_W = CODE_W + 1;

    logic [STAGES:0]   taps_ext;
    logic [STAGES-1:0] edge_hit;
    logic [IDX_W-1:0]  first_idx;

    assign taps_ext = {1'b0, taps};

    // An edge is a pair of adjacent zeros; a lone zero is a bubble
    for (genvar g = 0; g < STAGES; g++) begin : g_pair
        assign edge_hit[g] = ~taps_ext[g] & ~taps_ext[g+1];
    end

    always_comb begin
        first_idx = IDX_W'(STAGES);
        for (int i = STAGES - 1; i >= 0; i--) begin
            if (edge_hit[i]) first_idx = IDX_W'(i);
        end
    end

    assign code = (first_idx >= IDX_W'(STAGES - 1)) ? CODE_W'(STAGES - 1)
                                                    : first_idx[CODE_W-1:0];

    always_comb begin
        if (taps == '0) begin
            assert (code == '0) else $error("AST_ENC_EMPTY"); // R4
        end
    end

endmodule

// File: rtl/pix_coarse_cnt.sv
module pix_coarse_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             ovf_d
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
            r_d.ovf = 1'b0;
        end else if (en) begin
            if (r_q.cnt == CNT_MAX) r_d.ovf = 1'b1;
            else                    r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cnt_q = r_q.cnt;
    assign ovf_q = r_q.ovf;
    assign cnt_d = r_d.cnt;
    assign ovf_d = r_d.ovf;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)) // R5
        else $error("AST_CNT_STEP");

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && ovf_q)) // R6
        else $error("AST_CNT_SAT");

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !ovf_q)) // R5
        else $error("AST_CNT_CLR");

endmodule

// File: rtl/pix_tdc_ctrl.sv
module pix_tdc_ctrl
    import pix_tdc_pkg::*;
#(
    parameter int FINE_W = 4,
    parameter int CRS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ev,
    input  logic              stop,
    input  logic              rd_ack,
    input  logic [FINE_W-1:0] fine_code,
    input  logic [CRS_W-1:0]  crs_next,
    input  logic              ovf_next,
    output logic              cnt_clr,
    output logic              cnt_en,
    output logic              res_done,
    output logic              res_valid,
    output logic              res_ovf,
    output logic [FINE_W-1:0] res_fine,
    output logic [CRS_W-1:0]  res_coarse
);
    typedef struct packed {
        tdc_state_e        state;
        logic [FINE_W-1:0] fine;
        logic [FINE_W-1:0] out_fine;
        logic [CRS_W-1:0]  out_crs;
        logic              out_ovf;
        logic              out_valid;
        logic              out_done;
    } ctrl_reg_t;

    ctrl_reg_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        unique case (s_q.state)
            ST_WAIT: begin
                if (stop) begin
                    s_d.state     = ST_HOLD;
                    s_d.out_done  = 1'b1;
                    s_d.out_valid = 1'b0;
                    s_d.out_fine  = '0;
                    s_d.out_crs   = '0;
                    s_d.out_ovf   = 1'b0;
                end else if (start_ev) begin
                    s_d.state = ST_COUNT;
                    s_d.fine  = fine_code;
                    cnt_clr   = 1'b1;
                end
            end
            ST_COUNT: begin
                cnt_en = 1'b1;
                if (stop) begin
                    s_d.state     = ST_HOLD;
                    s_d.out_done  = 1'b1;
                    s_d.out_valid = 1'b1;
                    s_d.out_fine  = s_q.fine;
                    s_d.out_crs   = crs_next;
                    s_d.out_ovf   = ovf_next;
                end
            end
            ST_HOLD: begin
                if (rd_ack) begin
                    s_d.state     = ST_WAIT;
                    s_d.out_done  = 1'b0;
                    s_d.out_valid = 1'b0;
                    s_d.out_fine  = '0;
                    s_d.out_crs   = '0;
                    s_d.out_ovf   = 1'b0;
                end
            end
            default: s_d.state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_WAIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign res_done   = s_q.out_done;
    assign res_valid  = s_q.out_valid;
    assign res_ovf    = s_q.out_ovf;
    assign res_fine   = s_q.out_fine;
    assign res_coarse = s_q.out_crs;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT && !start_ev && !stop) |=> (s_q.state == ST_WAIT && !res_done)) // R2
        else $error("AST_IDLE_QUIET");

    AST_FIRST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_COUNT && !stop) |=> (s_q.state == ST_COUNT && $stable(s_q.fine))) // R9
        else $error("AST_FIRST_START");

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !rd_ack) |=> (res_done && $stable(res_coarse) && $stable(res_fine)
                                   && $stable(res_valid))) // R7
        else $error("AST_HOLD_STABLE");

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !res_valid) |-> (res_fine == '0 && res_coarse == '0 && !res_ovf)) // R8
        else $error("AST_INVALID_ZERO");

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && rd_ack) |=> (!res_done && !res_valid && res_coarse == '0)) // R10
        else $error("AST_ACK_CLEARS");

endmodule

// File: rtl/pix_tdc_core.sv
module pix_tdc_core #(
    parameter int STAGES = 16,
    parameter int CRS_W  = 10,
    localparam int FINE_W = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_start,
    input  logic              dummy_start,
    input  logic              dummy_sel,
    input  logic [STAGES-1:0] dline_taps,
    input  logic              stop,
    input  logic              rd_ack,
    output logic              res_done,
    output logic              res_valid,
    output logic              res_ovf,
    output logic [FINE_W-1:0] res_fine,
    output logic [CRS_W-1:0]  res_coarse
);
    logic              start_ev;
    logic [FINE_W-1:0] enc_code;
    logic              cnt_clr, cnt_en;
    logic [CRS_W-1:0]  crs_q, crs_d;
    logic              ovf_q, ovf_d;

    assign start_ev = dummy_sel ? dummy_start : det_start;

    pix_therm_enc #(.STAGES(STAGES)) i_enc (
        .taps (dline_taps),
        .code (enc_code)
    );

    pix_coarse_cnt #(.CNT_W(CRS_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .cnt_q (crs_q),
        .ovf_q (ovf_q),
        .cnt_d (crs_d),
        .ovf_d (ovf_d)
    );

    pix_tdc_ctrl #(.FINE_W(FINE_W), .CRS_W(CRS_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ev   (start_ev),
        .stop       (stop),
        .rd_ack     (rd_ack),
        .fine_code  (enc_code),
        .crs_next   (crs_d),
        .ovf_next   (ovf_d),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .res_done   (res_done),
        .res_valid  (res_valid),
        .res_ovf    (res_ovf),
        .res_fine   (res_fine),
        .res_coarse (res_coarse)
    );

    AST_OVF_MEANS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        res_ovf |-> (res_coarse == '1 && res_valid)) // R6
        else $error("AST_OVF_MEANS_SAT");

endmodule

// File: tb/test_pix_tdc_core.sv
module test_pix_tdc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_start = 1'b0, dummy_start = 1'b0, dummy_sel = 1'b0;
    logic [15:0] dline_taps = '0;
    logic        stop = 1'b0, rd_ack = 1'b0;
    logic        res_done, res_valid, res_ovf;
    logic [3:0]  res_fine;
    logic [9:0]  res_coarse;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pix_tdc_core i_pix_tdc_core (
        .clk(clk), .rst_n(rst_n), .det_start(det_start), .dummy_start(dummy_start),
        .dummy_sel(dummy_sel), .dline_taps(dline_taps), .stop(stop), .rd_ack(rd_ack),
        .res_done(res_done), .res_valid(res_valid), .res_ovf(res_ovf),
        .res_fine(res_fine), .res_coarse(res_coarse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_fine(input logic [15:0] t);
        for (int i = 0; i < 16; i++) begin
            if (!t[i] && (i == 15 || !t[i+1])) return (i > 15) ? 15 : i;
        end
        return 15;
    endfunction

    function automatic logic [15:0] rand_taps();
        int n = $urandom_range(0, 16);
        logic [15:0] t;
        if ($urandom_range(0, 5) == 0) return 16'($urandom());
        t = (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
        if (n >= 3 && $urandom_range(0, 2) == 0) t[$urandom_range(1, n - 2)] = 1'b0;
        return t;
    endfunction

    task automatic ack_and_check();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        chk("R10 done cleared", int'(res_done), 0);
        chk("R10 coarse cleared", int'(res_coarse), 0);
        chk("R10 fine cleared", int'(res_fine), 0);
    endtask

    // k: edges from the starting edge to the stop edge (k >= 1)
    task automatic conv(input logic sel, input logic [15:0] t, input int k, input logic extra);
        int ef = exp_fine(t);
        int ec = (k > 1023) ? 1023 : k;
        int eo = (k > 1023) ? 1 : 0;
        dummy_sel = sel;
        dline_taps = t;
        if (sel) dummy_start = 1'b1; else det_start = 1'b1;
        @(negedge clk);
        dummy_start = 1'b0;
        det_start = 1'b0;
        dline_taps = ~t;
        for (int i = 1; i < k; i++) begin
            if (extra && i < 4) begin
                det_start = 1'b1;
                dummy_start = 1'b1;
                dline_taps = 16'($urandom());
            end else begin
                det_start = 1'b0;
                dummy_start = 1'b0;
            end
            @(negedge clk);
        end
        det_start = 1'b0;
        dummy_start = 1'b0;
        chk("R7 no result before stop", int'(res_done), 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R7 done", int'(res_done), 1);
        chk("R7 valid", int'(res_valid), 1);
        chk(extra ? "R9 fine from first start" : "R4 fine code", int'(res_fine), ef);
        chk("R5 coarse count", int'(res_coarse), ec);
        chk("R6 overflow flag", int'(res_ovf), eo);
        // start and stop while held are ignored
        stop = 1'b1;
        det_start = 1'b1;
        dummy_start = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        det_start = 1'b0;
        dummy_start = 1'b0;
        chk("R7 held coarse", int'(res_coarse), ec);
        chk("R7 held fine", int'(res_fine), ef);
        ack_and_check();
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(res_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", int'(res_valid), 0);
        chk("R1 reset coarse", int'(res_coarse), 0);
        chk("R1 reset fine", int'(res_fine), 0);

        // R2: idle with no event
        repeat (5) @(negedge clk);
        chk("R2 idle no result", int'(res_done), 0);

        // R3: unselected source ignored, then stop gives an invalid result
        dummy_sel = 1'b1;
        det_start = 1'b1;
        @(negedge clk);
        det_start = 1'b0;
        repeat (3) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R3 det ignored when dummy selected", int'(res_valid), 0);
        chk("R8 done on lone stop", int'(res_done), 1);
        chk("R8 coarse zero", int'(res_coarse), 0);
        ack_and_check();

        // R8: stop coinciding with start
        dummy_sel = 1'b0;
        det_start = 1'b1;
        stop = 1'b1;
        dline_taps = 16'h00FF;
        @(negedge clk);
        det_start = 1'b0;
        stop = 1'b0;
        chk("R8 coincident valid", int'(res_valid), 0);
        chk("R8 coincident fine", int'(res_fine), 0);
        ack_and_check();

        // Directed fine-code and timing corners
        conv(1'b1, 16'h0000, 1, 1'b0);
        conv(1'b0, 16'hFFFF, 2, 1'b0);
        conv(1'b1, 16'h7FFF, 3, 1'b0);
        conv(1'b0, 16'h00FB, 5, 1'b0);
        conv(1'b1, 16'h0F0F, 4, 1'b1);
        conv(1'b0, 16'h003F, 1023, 1'b0);
        conv(1'b1, 16'h0007, 1024, 1'b0);
        conv(1'b0, 16'h01FF, 1300, 1'b0);

        for (int n = 0; n < 60; n++) begin
            conv(1'($urandom_range(0, 1)), rand_taps(), $urandom_range(1, 40),
                 1'($urandom_range(0, 3) == 0));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule